// File: doc/BRIEF.md
# Three-Wire Variable-Length Loader

This block receives serial configuration words over a three-wire link: an enable line, a clock line and a data line. A word starts when the enable line goes high. Each falling edge of the serial clock shifts in one data bit, most significant bit first within each field. Three word lengths are legal: 18, 19 and 27 bits. The block does not need the length in advance. It counts the bits and decides when each register takes its new value.

Every word begins with four band-switch bits. The block copies them into the switch register as soon as the fifth serial clock rises. The divider bits come next. For short words (18 or 19 bits) they transfer when the enable line falls. For long words (27 bits) they transfer on the 20th rising clock. A long word then carries one unused bit and seven control bits, and those control bits transfer when the enable line falls. All three pins pass through a synchronizer into the system clock domain, so each register changes a fixed number of system clocks after the pin edge that triggers it.

Top module: `three_wire_loader`

## Requirements
- R1: After reset the switch register is 4'b1111, the divider register is 0 and the control register is 7'b1000000 (bit 6 is the charge-pump current select, bit 0 is the amplifier disable).
- R2: A bit is accepted only on a serial clock falling edge while the enable line is high; serial clock and data activity while the enable line is low changes no output.
- R3: On the fifth rising serial clock of a frame, the switch register takes the first four received bits, with the first received bit placed in bit 3; before that rising edge the switch register keeps its old value.
- R4: When the enable line falls after exactly 18 bits, the divider register becomes {1'b0, last 14 bits}, so the divider's top bit is cleared.
- R5: When the enable line falls after exactly 19 bits, the divider register becomes the last 15 bits received, first received bit in bit 14.
- R6: In a frame that reaches a 20th rising serial clock, the divider register takes bits 5 to 19 of the frame on that edge, before the enable line falls.
- R7: When the enable line falls after exactly 27 bits, the control register takes the last seven bits (first of them in bit 6); bit 20 of the frame is ignored, and the control register does not change earlier in the frame.
- R8: Frames of 18 or 19 bits leave the control register unchanged.
- R9: If the enable line falls after any bit count other than 18, 19 or 27, nothing transfers at that point; updates already made on the fifth or 20th rising clock are kept. The bit count saturates, so very long frames never wrap to a legal count.
- R10: The bit counter restarts at zero for every frame, so a frame with a bad length does not disturb the next one.
- R11: A register updates on the third system clock edge after the pin edge that triggers it (two synchronizer stages plus edge detection).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ceIn | input | 1 | Frame enable pin, high while a word is sent |
| sclIn | input | 1 | Serial clock pin |
| sdaIn | input | 1 | Serial data pin |
| swReg | output | 4 | Band-switch register |
| divReg | output | 15 | Divider register |
| ctlReg | output | 7 | Control register |

## Verification
The bench sends words of the three legal lengths in a fixed order: a 19-bit word, then an 18-bit word, then a 27-bit word. With this order the 18-bit word must clear a divider top bit that the 19-bit word set, and only the 27-bit word may change the control register. It stops part-way through frames to show when each register changes. The switch register must not change before the fifth rising clock. For long words, the divider must change on the 20th rising clock and the control register must wait for the enable line to fall. Frames of 10, 22 and 50 bits check that a bad length transfers nothing at the end while keeping updates already made. The 50-bit frame would wrap to 18 on a counter that did not saturate. Clock toggling with the enable line low, followed by a clean frame, checks that idle activity is ignored and that the counter restarts. A behavioural model tracks every system clock and checks the three-edge latency.

// File: rtl/loader_pkg.sv
package loader_pkg;

  // Strobes from the control section to the datapath, one cycle wide.
  typedef struct packed {
    logic shift;        // accept one serial bit
    logic loadSw;       // fifth rising clock: switch bits
    logic loadDivEarly; // 20th rising clock: divider bits of a long word
    logic loadDivShort; // enable fall after short word without top bit
    logic loadDivFull;  // enable fall after short word with top bit
    logic loadCtl;      // enable fall after long word
  } loadStrobes_t;

endpackage

// File: rtl/loader_sync.sv
module loader_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic ceIn,
  input  logic sclIn,
  input  logic sdaIn,
  output logic ceLvl,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic ceFall
);

  localparam int CH = 3;

  logic [STAGES-1:0][CH-1:0] stg;
  logic                      cePrev;
  logic                      sclPrev;
  logic                      ceQ;
  logic                      sclQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stg <= '0;
    end else begin
      stg[0] <= {ceIn, sclIn, sdaIn};
      for (int i = 1; i < STAGES; i++) begin
        stg[i] <= stg[i-1];
      end
    end
  end

  assign ceQ    = stg[STAGES-1][2];
  assign sclQ   = stg[STAGES-1][1];
  assign sdaLvl = stg[STAGES-1][0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cePrev  <= 1'b0;
      sclPrev <= 1'b0;
    end else begin
      cePrev  <= ceQ;
      sclPrev <= sclQ;
    end
  end

  assign ceLvl   = ceQ;
  assign sclRise = sclQ & ~sclPrev;
  assign sclFall = ~sclQ & sclPrev;
  assign ceFall  = ~ceQ & cePrev;

endmodule

// File: rtl/loader_ctrl.sv
module loader_ctrl
  import loader_pkg::*;
#(
  parameter int SW_W  = 4,
  parameter int DIV_W = 15,
  parameter int CTL_W = 7,
  parameter int CNT_W = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ceLvl,
  input  logic               sclRise,
  input  logic               sclFall,
  input  logic               ceFall,
  output logic [CNT_W-1:0]   bitCnt,
  output loadStrobes_t       strb
);

  localparam int SHORT_LEN = SW_W + DIV_W - 1;
  localparam int MID_LEN   = SW_W + DIV_W;
  localparam int LONG_LEN  = MID_LEN + 1 + CTL_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (!ceLvl) begin
      bitCnt <= '0;
    end else if (sclFall && bitCnt != CNT_MAX) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  always_comb begin
    strb              = '0;
    strb.shift        = ceLvl & sclFall;
    strb.loadSw       = ceLvl & sclRise & (bitCnt == CNT_W'(SW_W));
    strb.loadDivEarly = ceLvl & sclRise & (bitCnt == CNT_W'(MID_LEN));
    strb.loadDivShort = ceFall & (bitCnt == CNT_W'(SHORT_LEN));
    strb.loadDivFull  = ceFall & (bitCnt == CNT_W'(MID_LEN));
    strb.loadCtl      = ceFall & (bitCnt == CNT_W'(LONG_LEN));
  end

endmodule

// File: rtl/loader_dp.sv
module loader_dp
  import loader_pkg::*;
#(
  parameter int               SW_W    = 4,
  parameter int               DIV_W   = 15,
  parameter int               CTL_W   = 7,
  parameter logic [SW_W-1:0]  SW_RST  = '1,
  parameter logic [CTL_W-1:0] CTL_RST = 7'b1000000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sdaLvl,
  input  loadStrobes_t       strb,
  output logic [SW_W-1:0]    swReg,
  output logic [DIV_W-1:0]   divReg,
  output logic [CTL_W-1:0]   ctlReg
);

  localparam int MAX_A = (DIV_W > CTL_W) ? DIV_W : CTL_W;
  localparam int SR_W  = (MAX_A > SW_W) ? MAX_A : SW_W;

  logic [SR_W-1:0] sr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sr <= '0;
    end else if (strb.shift) begin
      sr <= {sr[SR_W-2:0], sdaLvl};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swReg <= SW_RST;
    end else if (strb.loadSw) begin
      swReg <= sr[SW_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divReg <= '0;
    end else if (strb.loadDivShort) begin
      divReg <= {1'b0, sr[DIV_W-2:0]};
    end else if (strb.loadDivFull || strb.loadDivEarly) begin
      divReg <= sr[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlReg <= CTL_RST;
    end else if (strb.loadCtl) begin
      ctlReg <= sr[CTL_W-1:0];
    end
  end

endmodule

// File: rtl/three_wire_loader.sv
module three_wire_loader
  import loader_pkg::*;
#(
  parameter int               SW_W        = 4,
  parameter int               DIV_W       = 15,
  parameter int               CTL_W       = 7,
  parameter int               SYNC_STAGES = 2,
  parameter logic [SW_W-1:0]  SW_RST      = '1,
  parameter logic [CTL_W-1:0] CTL_RST     = 7'b1000000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ceIn,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic [SW_W-1:0]  swReg,
  output logic [DIV_W-1:0] divReg,
  output logic [CTL_W-1:0] ctlReg
);

  localparam int LONG_LEN = SW_W + DIV_W + 1 + CTL_W;
  localparam int CNT_W    = $clog2(LONG_LEN + 2);

  logic             ceLvl;
  logic             sdaLvl;
  logic             sclRise;
  logic             sclFall;
  logic             ceFall;
  logic [CNT_W-1:0] bitCnt;
  loadStrobes_t     strb;

  loader_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .ceIn(ceIn), .sclIn(sclIn), .sdaIn(sdaIn),
    .ceLvl(ceLvl), .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .ceFall(ceFall)
  );

  loader_ctrl #(.SW_W(SW_W), .DIV_W(DIV_W), .CTL_W(CTL_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .ceLvl(ceLvl), .sclRise(sclRise),
    .sclFall(sclFall), .ceFall(ceFall), .bitCnt(bitCnt), .strb(strb)
  );

  loader_dp #(.SW_W(SW_W), .DIV_W(DIV_W), .CTL_W(CTL_W),
              .SW_RST(SW_RST), .CTL_RST(CTL_RST)) u_dp (
    .clk(clk), .rstN(rstN), .sdaLvl(sdaLvl), .strb(strb),
    .swReg(swReg), .divReg(divReg), .ctlReg(ctlReg)
  );

endmodule

// File: rtl/three_wire_loader_chk.sv
module three_wire_loader_chk #(
  parameter int SW_W  = 4,
  parameter int DIV_W = 15,
  parameter int CTL_W = 7,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic [SW_W-1:0]  swReg,
  input logic [DIV_W-1:0] divReg,
  input logic [CTL_W-1:0] ctlReg,
  input logic             ceLvl,
  input logic             ceFall,
  input logic             sclRise,
  input logic [CNT_W-1:0] bitCnt
);

  localparam logic [CNT_W-1:0] C_SW    = CNT_W'(SW_W);
  localparam logic [CNT_W-1:0] C_SHORT = CNT_W'(SW_W + DIV_W - 1);
  localparam logic [CNT_W-1:0] C_MID   = CNT_W'(SW_W + DIV_W);
  localparam logic [CNT_W-1:0] C_LONG  = CNT_W'(SW_W + DIV_W + 1 + CTL_W);

  AST_SW_ON_FIFTH_RISE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(swReg) |-> ($past(sclRise && ceLvl) && $past(bitCnt) == C_SW)); // R3

  AST_SHORT_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ceFall) && $past(bitCnt) == C_SHORT) |-> (divReg[DIV_W-1] == 1'b0)); // R4

  AST_CTL_ONLY_LONG_END: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ctlReg) |-> ($past(ceFall) && $past(bitCnt) == C_LONG)); // R7

  AST_DIV_LEGAL_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(divReg) |-> (($past(ceFall) && ($past(bitCnt) == C_SHORT || $past(bitCnt) == C_MID))
                          || ($past(sclRise && ceLvl) && $past(bitCnt) == C_MID))); // R9

  AST_CNT_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    !ceLvl |=> (bitCnt == '0)); // R10

  AST_CNT_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (bitCnt != $past(bitCnt)) |-> (bitCnt == '0 || bitCnt == $past(bitCnt) + 1'b1)); // R2

endmodule

bind three_wire_loader three_wire_loader_chk #(
  .SW_W(SW_W), .DIV_W(DIV_W), .CTL_W(CTL_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .swReg(swReg), .divReg(divReg), .ctlReg(ctlReg),
  .ceLvl(ceLvl), .ceFall(ceFall), .sclRise(sclRise), .bitCnt(bitCnt)
);

// File: tb/three_wire_loader_tb.sv
module three_wire_loader_tb;

  localparam int HALF = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ce = 1'b0;
  logic       scl = 1'b0;
  logic       sda = 1'b0;
  logic [3:0] swReg;
  logic [14:0] divReg;
  logic [6:0] ctlReg;

  int errors = 0;
  int checks = 0;
  bit running = 1'b0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  three_wire_loader u_dut (
    .clk(clk), .rstN(rstN), .ceIn(ce), .sclIn(scl), .sdaIn(sda),
    .swReg(swReg), .divReg(divReg), .ctlReg(ctlReg)
  );

  // Behavioural reference: pins delayed by three edges, bit list, integer count.
  bit          q[$];
  int          cnt;
  logic [2:0]  d1, d2, d3;
  logic [3:0]  mSw;
  logic [14:0] mDiv;
  logic [6:0]  mCtl;
  logic [31:0] t;

  function automatic logic [31:0] tail(int k);
    logic [31:0] v = '0;
    for (int i = q.size() - k; i < q.size(); i++) v = {v[30:0], q[i]};
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mSw = 4'hF; mDiv = '0; mCtl = 7'b1000000; cnt = 0; q.delete();
      d1 = '0; d2 = '0; d3 = '0;
    end else begin
      if (!d2[2] && d3[2]) begin
        if (cnt == 18) begin t = tail(14); mDiv = {1'b0, t[13:0]}; end
        else if (cnt == 19) begin t = tail(15); mDiv = t[14:0]; end
        else if (cnt == 27) begin t = tail(7); mCtl = t[6:0]; end
      end
      if (d2[2] && d2[1] && !d3[1]) begin
        if (cnt == 4) begin t = tail(4); mSw = t[3:0]; end
        if (cnt == 19) begin t = tail(15); mDiv = t[14:0]; end
      end
      if (!d2[2]) begin
        cnt = 0; q.delete();
      end else if (!d2[1] && d3[1]) begin
        q.push_back(d2[0]);
        if (cnt < 31) cnt++;
      end
      d3 = d2; d2 = d1; d1 = {ce, scl, sda};
    end
  end

  always @(negedge clk) begin
    if (running) begin
      checks++;
      if (swReg !== mSw || divReg !== mDiv || ctlReg !== mCtl) begin
        errors++;
        $display("FAIL R11 per-clock model: act sw=%b div=%h ctl=%b exp sw=%b div=%h ctl=%b",
                 swReg, divReg, ctlReg, mSw, mDiv, mCtl);
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frameStart();
    ce = 1'b1; waitN(HALF);
  endtask

  task automatic frameEnd();
    ce = 1'b0; waitN(3 * HALF);
  endtask

  task automatic sendBits(int n, logic [31:0] v);
    for (int i = n - 1; i >= 0; i--) begin
      sda = v[i]; waitN(HALF);
      scl = 1'b1; waitN(HALF);
      scl = 1'b0; waitN(HALF);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    waitN(3);
    // R1: reset values
    chk("R1 sw reset", 32'(swReg), 32'hF);
    chk("R1 div reset", 32'(divReg), 32'h0);
    chk("R1 ctl reset", 32'(ctlReg), 32'h40);
    rstN = 1'b1;
    waitN(2);
    running = 1'b1;

    // R2: clock and data activity with the enable line low
    for (int i = 0; i < 12; i++) begin
      sda = i[0]; waitN(2); scl = 1'b1; waitN(2); scl = 1'b0; waitN(2);
    end
    waitN(HALF);
    chk("R2 sw idle", 32'(swReg), 32'hF);
    chk("R2 div idle", 32'(divReg), 32'h0);
    chk("R2 ctl idle", 32'(ctlReg), 32'h40);

    // 19-bit word: sw 0011, N 4321
    frameStart();
    sendBits(4, 32'b0011);
    chk("R3 sw before fifth rise", 32'(swReg), 32'hF);
    sendBits(15, 32'h4321);
    chk("R3 sw after fifth rise", 32'(swReg), 32'h3);
    chk("R5 div waits for enable fall", 32'(divReg), 32'h0);
    frameEnd();
    chk("R5 div 19-bit", 32'(divReg), 32'h4321);
    chk("R8 ctl after 19-bit", 32'(ctlReg), 32'h40);

    // 18-bit word: sw 1100, N13..N0 1234
    frameStart();
    sendBits(4, 32'b1100);
    sendBits(14, 32'h1234);
    frameEnd();
    chk("R4 div 18-bit top cleared", 32'(divReg), 32'h1234);
    chk("R3 sw 18-bit", 32'(swReg), 32'hC);
    chk("R8 ctl after 18-bit", 32'(ctlReg), 32'h40);

    // 27-bit word: sw 1001, N 2D5A, unused 1, ctl 0110101
    frameStart();
    sendBits(4, 32'b1001);
    sendBits(15, 32'h2D5A);
    chk("R6 div before 20th rise", 32'(divReg), 32'h1234);
    sendBits(1, 32'h1);
    chk("R6 div on 20th rise", 32'(divReg), 32'h2D5A);
    sendBits(7, 32'b0110101);
    chk("R7 ctl waits for enable fall", 32'(ctlReg), 32'h40);
    frameEnd();
    chk("R7 ctl 27-bit", 32'(ctlReg), 32'h35);
    chk("R7 div kept 27-bit", 32'(divReg), 32'h2D5A);
    chk("R3 sw 27-bit", 32'(swReg), 32'h9);

    // 10-bit frame: switch update kept, nothing else
    frameStart();
    sendBits(10, 32'b0110_111111);
    frameEnd();
    chk("R9 sw kept 10-bit", 32'(swReg), 32'h6);
    chk("R9 div 10-bit", 32'(divReg), 32'h2D5A);
    chk("R9 ctl 10-bit", 32'(ctlReg), 32'h35);

    // 22-bit frame: early divider kept, control untouched
    frameStart();
    sendBits(4, 32'b1111);
    sendBits(15, 32'h0F0F);
    sendBits(3, 32'b101);
    frameEnd();
    chk("R9 div early kept 22-bit", 32'(divReg), 32'h0F0F);
    chk("R9 ctl 22-bit", 32'(ctlReg), 32'h35);

    // 50-bit frame: count must saturate, not wrap to 18
    frameStart();
    sendBits(4, 32'b0000);
    sendBits(15, 32'h7001);
    sendBits(31, 32'h7FFFFFFF);
    frameEnd();
    chk("R9 div 50-bit saturate", 32'(divReg), 32'h7001);
    chk("R9 ctl 50-bit", 32'(ctlReg), 32'h35);
    chk("R9 sw 50-bit", 32'(swReg), 32'h0);

    // R10: clean 19-bit frame after bad lengths
    frameStart();
    sendBits(4, 32'b1010);
    sendBits(15, 32'h0ABC);
    frameEnd();
    chk("R10 div restart", 32'(divReg), 32'h0ABC);
    chk("R10 sw restart", 32'(swReg), 32'hA);
    chk("R10 ctl restart", 32'(ctlReg), 32'h35);

    waitN(4);
    running = 1'b0;
    summary();
  end

endmodule